// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches four bus interfaces at once: an instruction fetch bus, a data memory bus, an internal bus driven by the CPU and an internal bus driven by the DMA engine. It raises a break request when an access matches a condition that has been programmed into one of two independent channels. A channel's condition is built from several parts:
- an address value and mask;
- a data value and mask;
- a choice of bus, and of master when the internal bus is chosen;
- qualifiers for cycle type, direction and operand size.

Every qualifier has a don't-care code.

A fetch match can raise its break at once, which is the pre-execution timing. It can instead wait for the fetched instruction to retire, which is the post-execution timing: the channel holds the fetch address pending until a retire strobe carries the same address. Each channel's break request is sticky until software clears it. Any matching access also produces a registered trigger pulse. Configuration is written through a simple write-only register port.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset, brk_req, brk_post and trig_o are all 0, every channel is disabled and nothing is pending.
- R2: The address compare covers all address bits. A mask bit of 1 removes that bit position from the compare.
- R3: The data compare covers all data bits. A mask bit of 1 removes that bit position from the compare. The data comes from the same bus as the selected data-access address.
- R4: The control bit 6 selects the bus: 0 is the CPU side and 1 is the internal bus. On the CPU side, fetch conditions use fb_addr and data conditions use the mb_* bus. On the internal bus, control bit 7 selects the master: 0 is cb_* (CPU) and 1 is db_* (DMA).
- R5: Control bits [1:0] set the cycle type: 01 is fetch only, 10 is data only, and 00 or 11 accepts either. A fetch never matches when control bit 6 is 1.
- R6: Control bits [3:2] set the direction: 01 is reads only (*_wr=0), 10 is writes only, and 00 or 11 accepts either. A fetch counts as a read.
- R7: Control bits [5:4] set the operand size: 00 is don't care, 01 is byte, 10 is word and 11 is longword. These match a bus size of 00 (byte), 01 (word) and 10 (longword). The data and size qualifiers do not apply to fetches.
- R8: With control bit 8 = 0, a matching fetch sets brk_req[c] after the clock edge that samples it, and brk_post[c] stays 0.
- R9: With control bit 8 = 1, a matching fetch stores its address as pending and does not set brk_req. A later ret_vld carrying that exact address sets brk_req[c] and brk_post[c] and consumes the pending entry.
- R10: brk_req[c] is sticky. Writing 1 to bit c at config address all-ones clears it, together with brk_post[c]. A match in the same cycle as the clear wins, and the flag stays set.
- R11: trig_o is high for exactly the cycle after each cycle in which any channel sees a matching access, whatever the fetch timing.
- R12: Channels are independent. Channel c registers live at config address c*8 + {0 address, 1 address mask, 2 data, 3 data mask, 4 control}.
- R13: Control bit 9 enables the channel. While it is 0, the channel never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config register address |
| cfg_wdata | input | CW | Config write data |
| fb_vld | input | 1 | Fetch bus access strobe |
| fb_addr | input | AW | Fetch address |
| mb_vld | input | 1 | Memory bus access strobe |
| mb_addr | input | AW | Memory bus address |
| mb_data | input | DW | Memory bus data |
| mb_wr | input | 1 | Memory bus write (1) / read (0) |
| mb_size | input | 2 | Memory bus size: 00 byte, 01 word, 10 long |
| cb_vld | input | 1 | Internal CPU-master access strobe |
| cb_addr | input | AW | Internal CPU-master address |
| cb_data | input | DW | Internal CPU-master data |
| cb_wr | input | 1 | Internal CPU-master write |
| cb_size | input | 2 | Internal CPU-master size |
| db_vld | input | 1 | Internal DMA-master access strobe |
| db_addr | input | AW | Internal DMA-master address |
| db_data | input | DW | Internal DMA-master data |
| db_wr | input | 1 | Internal DMA-master write |
| db_size | input | 2 | Internal DMA-master size |
| ret_vld | input | 1 | Instruction retire strobe |
| ret_addr | input | AW | Address of the retiring instruction |
| brk_req | output | NUM_CH | Sticky break request per channel |
| brk_post | output | NUM_CH | Set when the request came from a post-execution fetch break |
| trig_o | output | 1 | One-cycle trigger after any matching access |

## Verification
Each qualifier is tried with at least one access that meets it and one that misses by one field. The misses include:
- an address outside the mask;
- a data bit that the mask does not exclude;
- the wrong master or bus;
- a write against a read-only condition;
- a byte access against a word condition.

These pairs show that each field takes part in the decision rather than being ignored. The post-execution tests retire a different address before retiring the matching one, and then retire the matching address a second time. This separates exact address matching from any retire and shows that the pending entry is consumed. Back-to-back hits, a hit in the same cycle as a clear, and a DMA access that hits only the second channel separate the trigger timing, the clear priority and channel independence.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

   localparam int REG_STRIDE = 8;
   localparam int OFF_AV     = 0;
   localparam int OFF_AM     = 1;
   localparam int OFF_DV     = 2;
   localparam int OFF_DM     = 3;
   localparam int OFF_CTL    = 4;
   localparam int CTRL_W     = 10;

   localparam logic [1:0] CYC_FETCH = 2'b01;
   localparam logic [1:0] CYC_DATA  = 2'b10;
   localparam logic [1:0] RW_READ   = 2'b01;
   localparam logic [1:0] RW_WRITE  = 2'b10;

   // Control word: en[9] post[8] master[7] ibus[6] size[5:4] rw[3:2] cyc[1:0]
   typedef struct packed {
      logic       en;
      logic       post;
      logic       master;
      logic       ibus;
      logic [1:0] size;
      logic [1:0] rw;
      logic [1:0] cyc;
   } ctrl_t;

   function automatic logic rw_ok(input logic [1:0] q, input logic is_wr);
      case (q)
         RW_READ:  return !is_wr;
         RW_WRITE: return is_wr;
         default:  return 1'b1;
      endcase
   endfunction

   function automatic logic size_ok(input logic [1:0] q, input logic [1:0] bus_sz);
      logic [1:0] code;
      code = bus_sz + 2'd1;
      return (q == 2'b00) || (q == code);
   endfunction

endpackage

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
   import dbg_brk_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int CW     = 32,
   parameter int CFG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CW-1:0]     cfg_wdata,
   output logic [AW-1:0]     addr_val [NUM_CH],
   output logic [AW-1:0]     addr_msk [NUM_CH],
   output logic [DW-1:0]     data_val [NUM_CH],
   output logic [DW-1:0]     data_msk [NUM_CH],
   output ctrl_t             ctrl     [NUM_CH],
   output logic [NUM_CH-1:0] clr
);

   localparam logic [CFG_AW-1:0] STAT_ADDR = '1;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int BASE = c * REG_STRIDE;
      logic [AW-1:0] av_q, am_q;
      logic [DW-1:0] dv_q, dm_q;
      ctrl_t         ctl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            av_q  <= '0;
            am_q  <= '0;
            dv_q  <= '0;
            dm_q  <= '0;
            ctl_q <= '0;
         end else if (cfg_we) begin
            if (int'(cfg_addr) == BASE + OFF_AV)  av_q  <= cfg_wdata[AW-1:0];
            if (int'(cfg_addr) == BASE + OFF_AM)  am_q  <= cfg_wdata[AW-1:0];
            if (int'(cfg_addr) == BASE + OFF_DV)  dv_q  <= cfg_wdata[DW-1:0];
            if (int'(cfg_addr) == BASE + OFF_DM)  dm_q  <= cfg_wdata[DW-1:0];
            if (int'(cfg_addr) == BASE + OFF_CTL) ctl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
         end
      end

      assign addr_val[c] = av_q;
      assign addr_msk[c] = am_q;
      assign data_val[c] = dv_q;
      assign data_msk[c] = dm_q;
      assign ctrl[c]     = ctl_q;
      assign clr[c]      = cfg_we && (cfg_addr == STAT_ADDR) && cfg_wdata[c];
   end

endmodule

// File: rtl/dbg_brk_match.sv
module dbg_brk_match
   import dbg_brk_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  ctrl_t         ctrl,
   input  logic [AW-1:0] addr_val,
   input  logic [AW-1:0] addr_msk,
   input  logic [DW-1:0] data_val,
   input  logic [DW-1:0] data_msk,
   input  logic          fb_vld,
   input  logic [AW-1:0] fb_addr,
   input  logic          mb_vld,
   input  logic [AW-1:0] mb_addr,
   input  logic [DW-1:0] mb_data,
   input  logic          mb_wr,
   input  logic [1:0]    mb_size,
   input  logic          cb_vld,
   input  logic [AW-1:0] cb_addr,
   input  logic [DW-1:0] cb_data,
   input  logic          cb_wr,
   input  logic [1:0]    cb_size,
   input  logic          db_vld,
   input  logic [AW-1:0] db_addr,
   input  logic [DW-1:0] db_data,
   input  logic          db_wr,
   input  logic [1:0]    db_size,
   output logic          fetch_hit,
   output logic          data_hit
);

   logic          s_vld, s_wr;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_data;
   logic [1:0]    s_size;

   // Data-access source: CPU-side memory bus, or internal bus by master
   always_comb begin
      if (!ctrl.ibus) begin
         s_vld = mb_vld; s_addr = mb_addr; s_data = mb_data; s_wr = mb_wr; s_size = mb_size;
      end else if (ctrl.master) begin
         s_vld = db_vld; s_addr = db_addr; s_data = db_data; s_wr = db_wr; s_size = db_size;
      end else begin
         s_vld = cb_vld; s_addr = cb_addr; s_data = cb_data; s_wr = cb_wr; s_size = cb_size;
      end
   end

   logic want_fetch, want_data, f_aeq, s_aeq, s_deq;

   assign want_fetch = (ctrl.cyc != CYC_DATA) && !ctrl.ibus;
   assign want_data  = (ctrl.cyc != CYC_FETCH);
   assign f_aeq = ((fb_addr ^ addr_val) & ~addr_msk) == '0;
   assign s_aeq = ((s_addr  ^ addr_val) & ~addr_msk) == '0;
   assign s_deq = ((s_data  ^ data_val) & ~data_msk) == '0;

   assign fetch_hit = ctrl.en && want_fetch && fb_vld && f_aeq && rw_ok(ctrl.rw, 1'b0);
   assign data_hit  = ctrl.en && want_data && s_vld && s_aeq && s_deq
                      && rw_ok(ctrl.rw, s_wr) && size_ok(ctrl.size, s_size);

endmodule

// File: rtl/dbg_brk_chan.sv
module dbg_brk_chan #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_hit,
   input  logic          data_hit,
   input  logic          post_cfg,
   input  logic [AW-1:0] fb_addr,
   input  logic          ret_vld,
   input  logic [AW-1:0] ret_addr,
   input  logic          clr,
   output logic          flag,
   output logic          post_flag
);

   logic          pend_q, flag_q, post_q;
   logic [AW-1:0] paddr_q;
   logic          imm, ret_hit, set;

   assign imm     = data_hit || (fetch_hit && !post_cfg);
   assign ret_hit = pend_q && ret_vld && (ret_addr == paddr_q);
   assign set     = imm || ret_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         paddr_q <= '0;
         flag_q  <= 1'b0;
         post_q  <= 1'b0;
      end else begin
         if (fetch_hit && post_cfg) begin
            pend_q  <= 1'b1;
            paddr_q <= fb_addr;
         end else if (ret_hit) begin
            pend_q  <= 1'b0;
         end
         if (set)      flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
         if (set && (!flag_q || clr)) post_q <= !imm;
         else if (clr)                post_q <= 1'b0;
      end
   end

   assign flag      = flag_q;
   assign post_flag = post_q;

   // R10: a raised request holds until cleared
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr |=> flag_q) else $error("a_r10_sticky");
   // R10: a clear with no concurrent match drops the request
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !imm && !ret_hit |=> !flag_q) else $error("a_r10_clear");
   // R9: a post-execution request needs a retire in the previous cycle
   a_r9_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) && post_q |-> $past(ret_vld)) else $error("a_r9_needs_retire");
   // R8: an immediate request comes from a match in the previous cycle
   a_r8_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) && !post_q |-> $past(fetch_hit || data_hit)) else $error("a_r8_immediate");

endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
   import dbg_brk_pkg::*;
#(
   parameter  int NUM_CH = 2,
   parameter  int AW     = 32,
   parameter  int DW     = 32,
   localparam int CW     = (AW > DW) ? AW : DW,
   localparam int CFG_AW = $clog2(NUM_CH * REG_STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CW-1:0]     cfg_wdata,
   input  logic              fb_vld,
   input  logic [AW-1:0]     fb_addr,
   input  logic              mb_vld,
   input  logic [AW-1:0]     mb_addr,
   input  logic [DW-1:0]     mb_data,
   input  logic              mb_wr,
   input  logic [1:0]        mb_size,
   input  logic              cb_vld,
   input  logic [AW-1:0]     cb_addr,
   input  logic [DW-1:0]     cb_data,
   input  logic              cb_wr,
   input  logic [1:0]        cb_size,
   input  logic              db_vld,
   input  logic [AW-1:0]     db_addr,
   input  logic [DW-1:0]     db_data,
   input  logic              db_wr,
   input  logic [1:0]        db_size,
   input  logic              ret_vld,
   input  logic [AW-1:0]     ret_addr,
   output logic [NUM_CH-1:0] brk_req,
   output logic [NUM_CH-1:0] brk_post,
   output logic              trig_o
);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 4) else $fatal(1, "NUM_CH must be 1..4");
      assert (AW >= 8 && DW >= 8) else $fatal(1, "AW and DW must be at least 8");
      assert (CW >= CTRL_W) else $fatal(1, "config word narrower than control word");
   end

   logic [AW-1:0]     addr_val [NUM_CH];
   logic [AW-1:0]     addr_msk [NUM_CH];
   logic [DW-1:0]     data_val [NUM_CH];
   logic [DW-1:0]     data_msk [NUM_CH];
   ctrl_t             ctrl     [NUM_CH];
   logic [NUM_CH-1:0] clr, f_hit, d_hit;

   dbg_brk_regs #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .CW(CW), .CFG_AW(CFG_AW)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .addr_val, .addr_msk, .data_val, .data_msk, .ctrl, .clr
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dbg_brk_match #(.AW(AW), .DW(DW)) u_match (
         .ctrl(ctrl[c]), .addr_val(addr_val[c]), .addr_msk(addr_msk[c]),
         .data_val(data_val[c]), .data_msk(data_msk[c]),
         .fb_vld, .fb_addr,
         .mb_vld, .mb_addr, .mb_data, .mb_wr, .mb_size,
         .cb_vld, .cb_addr, .cb_data, .cb_wr, .cb_size,
         .db_vld, .db_addr, .db_data, .db_wr, .db_size,
         .fetch_hit(f_hit[c]), .data_hit(d_hit[c])
      );
      dbg_brk_chan #(.AW(AW)) u_chan (
         .clk, .rst_n,
         .fetch_hit(f_hit[c]), .data_hit(d_hit[c]), .post_cfg(ctrl[c].post),
         .fb_addr, .ret_vld, .ret_addr, .clr(clr[c]),
         .flag(brk_req[c]), .post_flag(brk_post[c])
      );
   end

   logic any_hit, trig_q;
   assign any_hit = |(f_hit | d_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= any_hit;
   end
   assign trig_o = trig_q;

   // R11: the trigger follows a matching access by exactly one cycle
   a_r11_trig_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(any_hit)) else $error("a_r11_trig_after_hit");
   // R13: a disabled channel never produces a hit
   a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[0].en |-> !f_hit[0] && !d_hit[0]) else $error("a_r13_disabled_quiet");

endmodule

// File: tb/dbg_brk_unit_bench.sv
module dbg_brk_unit_bench;

   localparam int AW = 32;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cfg_we = 0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        fb_vld = 0, mb_vld = 0, cb_vld = 0, db_vld = 0, ret_vld = 0;
   logic [31:0] fb_addr = '0, mb_addr = '0, cb_addr = '0, db_addr = '0, ret_addr = '0;
   logic [31:0] mb_data = '0, cb_data = '0, db_data = '0;
   logic        mb_wr = 0, cb_wr = 0, db_wr = 0;
   logic [1:0]  mb_size = '0, cb_size = '0, db_size = '0;
   logic [1:0]  brk_req, brk_post;
   logic        trig_o;

   dbg_brk_unit u_dbg_brk_unit (.*);

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 0;

   // ---------------- reference model ----------------
   logic [31:0] m_av [2], m_am [2], m_dv [2], m_dm [2], m_paddr [2];
   logic [9:0]  m_ctl [2];
   bit          m_flag [2], m_post [2], m_pend [2];
   bit          m_trig;

   function automatic bit q_rw(logic [1:0] q, logic w);
      if (q == 2'b01) return !w;
      if (q == 2'b10) return w;
      return 1;
   endfunction

   function automatic bit m_fetch(int c);
      if (!m_ctl[c][9] || m_ctl[c][6] || m_ctl[c][1:0] == 2'b10 || !fb_vld) return 0;
      if (((fb_addr ^ m_av[c]) & ~m_am[c]) != 0) return 0;
      return q_rw(m_ctl[c][3:2], 1'b0);
   endfunction

   function automatic bit m_data(int c);
      bit v, w; logic [31:0] a, d; int sz, q;
      if (!m_ctl[c][9] || m_ctl[c][1:0] == 2'b01) return 0;
      if (!m_ctl[c][6])     begin v = mb_vld; a = mb_addr; d = mb_data; w = mb_wr; sz = mb_size; end
      else if (m_ctl[c][7]) begin v = db_vld; a = db_addr; d = db_data; w = db_wr; sz = db_size; end
      else                  begin v = cb_vld; a = cb_addr; d = cb_data; w = cb_wr; sz = cb_size; end
      q = m_ctl[c][5:4];
      if (!v) return 0;
      if (((a ^ m_av[c]) & ~m_am[c]) != 0) return 0;
      if (((d ^ m_dv[c]) & ~m_dm[c]) != 0) return 0;
      if (!q_rw(m_ctl[c][3:2], w)) return 0;
      return (q == 0) || (q == sz + 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_av[c] = 0; m_am[c] = 0; m_dv[c] = 0; m_dm[c] = 0; m_ctl[c] = 0;
            m_flag[c] = 0; m_post[c] = 0; m_pend[c] = 0; m_paddr[c] = 0;
         end
         m_trig = 0;
      end else begin
         bit any;
         any = 0;
         for (int c = 0; c < 2; c++) begin
            bit fh, dh, imm, rh, st, cl;
            fh  = m_fetch(c);
            dh  = m_data(c);
            any = any | fh | dh;
            imm = dh || (fh && !m_ctl[c][8]);
            rh  = m_pend[c] && ret_vld && ret_addr == m_paddr[c];
            st  = imm || rh;
            cl  = cfg_we && cfg_addr == 4'hF && cfg_wdata[c];
            if (st && (!m_flag[c] || cl)) m_post[c] = !imm;
            else if (cl && !st)           m_post[c] = 0;
            if (st) m_flag[c] = 1; else if (cl) m_flag[c] = 0;
            if (fh && m_ctl[c][8]) begin m_pend[c] = 1; m_paddr[c] = fb_addr; end
            else if (rh) m_pend[c] = 0;
         end
         m_trig = any;
         if (cfg_we) begin
            for (int c = 0; c < 2; c++) begin
               if (cfg_addr == c*8 + 0) m_av[c]  = cfg_wdata;
               if (cfg_addr == c*8 + 1) m_am[c]  = cfg_wdata;
               if (cfg_addr == c*8 + 2) m_dv[c]  = cfg_wdata;
               if (cfg_addr == c*8 + 3) m_dm[c]  = cfg_wdata;
               if (cfg_addr == c*8 + 4) m_ctl[c] = cfg_wdata[9:0];
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_req, " model brk_req"},  {30'd0, brk_req},  {30'd0, m_flag[1], m_flag[0]});
         chk({cur_req, " model brk_post"}, {30'd0, brk_post}, {30'd0, m_post[1], m_post[0]});
         chk({cur_req, " model trig_o"},   {31'd0, trig_o},   {31'd0, m_trig});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfgw(input int a, input logic [31:0] d);
      cfg_we = 1; cfg_addr = a[3:0]; cfg_wdata = d;
      step();
      cfg_we = 0;
   endtask

   function automatic logic [31:0] ctl(bit en, bit post, bit mst, bit ib,
                                       logic [1:0] sz, logic [1:0] rw, logic [1:0] cy);
      return {22'd0, en, post, mst, ib, sz, rw, cy};
   endfunction

   task automatic setch(input int c, input logic [31:0] av, am, dv, dm, ct);
      cfgw(c*8 + 0, av); cfgw(c*8 + 1, am); cfgw(c*8 + 2, dv);
      cfgw(c*8 + 3, dm); cfgw(c*8 + 4, ct);
   endtask

   task automatic clear_all();
      cfgw(15, 32'h3);
   endtask

   task automatic mb_acc(input logic [31:0] a, d, input bit w, input logic [1:0] s);
      mb_vld = 1; mb_addr = a; mb_data = d; mb_wr = w; mb_size = s;
      step(); mb_vld = 0;
   endtask
   task automatic cb_acc(input logic [31:0] a, d);
      cb_vld = 1; cb_addr = a; cb_data = d; cb_wr = 0; cb_size = 2'b10;
      step(); cb_vld = 0;
   endtask
   task automatic db_acc(input logic [31:0] a, d);
      db_vld = 1; db_addr = a; db_data = d; db_wr = 1; db_size = 2'b10;
      step(); db_vld = 0;
   endtask
   task automatic fb_acc(input logic [31:0] a);
      fb_vld = 1; fb_addr = a;
      step(); fb_vld = 0;
   endtask
   task automatic retire(input logic [31:0] a);
      ret_vld = 1; ret_addr = a;
      step(); ret_vld = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 brk_req",  {30'd0, brk_req},  32'd0);
      chk("R1 brk_post", {30'd0, brk_post}, 32'd0);
      chk("R1 trig_o",   {31'd0, trig_o},   32'd0);
      rst_n = 1;
      step();
      mb_acc(32'h0, 32'h0, 0, 2'b10);
      chk("R1 disabled after reset", {30'd0, brk_req}, 32'd0);

      // R2 / R4: memory-bus data condition with address mask
      cur_req = "R2";
      setch(0, 32'h1000_0040, 32'h0, 32'h0, 32'hFFFF_FFFF, ctl(1,0,0,0,2'b00,2'b00,2'b10));
      mb_acc(32'h1000_0044, 32'h0, 0, 2'b10);
      chk("R2 near address", {30'd0, brk_req}, 32'd0);
      mb_acc(32'h1000_0040, 32'h0, 0, 2'b10);
      chk("R2 exact address", {30'd0, brk_req}, 32'd1);
      chk("R11 trigger after hit", {31'd0, trig_o}, 32'd1);
      cfgw(15, 32'h1);
      chk("R10 cleared", {30'd0, brk_req}, 32'd0);
      chk("R11 trigger one cycle", {31'd0, trig_o}, 32'd0);
      cfgw(1, 32'h0000_00FF);
      mb_acc(32'h1000_00C4, 32'h0, 0, 2'b10);
      chk("R2 masked bits ignored", {30'd0, brk_req}, 32'd1);
      clear_all();
      mb_acc(32'h1000_0140, 32'h0, 0, 2'b10);
      chk("R2 unmasked bit differs", {30'd0, brk_req}, 32'd0);

      // R3: data compare on internal CPU master
      cur_req = "R3";
      setch(0, 32'h2000, 32'h0, 32'hA5A5_0000, 32'h0000_FFFF, ctl(1,0,0,1,2'b00,2'b00,2'b10));
      cb_acc(32'h2000, 32'hA5A5_1234);
      chk("R3 data masked match", {30'd0, brk_req}, 32'd1);
      clear_all();
      cb_acc(32'h2000, 32'hA5A4_1234);
      chk("R3 data mismatch", {30'd0, brk_req}, 32'd0);
      mb_acc(32'h2000, 32'hA5A5_0000, 0, 2'b10);
      chk("R4 memory bus not watched", {30'd0, brk_req}, 32'd0);

      // R4: DMA master selection
      cur_req = "R4";
      cfgw(4, ctl(1,0,1,1,2'b00,2'b00,2'b10));
      cb_acc(32'h2000, 32'hA5A5_0000);
      chk("R4 CPU master ignored", {30'd0, brk_req}, 32'd0);
      db_acc(32'h2000, 32'hA5A5_0000);
      chk("R4 DMA master hit", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R5: cycle type
      cur_req = "R5";
      setch(0, 32'h3000, 32'h0, 32'h0, 32'hFFFF_FFFF, ctl(1,0,0,1,2'b00,2'b00,2'b01));
      fb_acc(32'h3000);
      chk("R5 fetch on internal bus", {30'd0, brk_req}, 32'd0);
      cb_acc(32'h3000, 32'h0);
      chk("R5 data access vs fetch", {30'd0, brk_req}, 32'd0);
      cfgw(4, ctl(1,0,0,0,2'b00,2'b00,2'b01));
      fb_acc(32'h3000);
      chk("R5 fetch on CPU side", {30'd0, brk_req}, 32'd1);
      chk("R8 pre-execution post flag", {30'd0, brk_post}, 32'd0);
      clear_all();
      cfgw(4, ctl(1,0,0,0,2'b00,2'b00,2'b10));
      fb_acc(32'h3000);
      chk("R5 data-only ignores fetch", {30'd0, brk_req}, 32'd0);
      cfgw(4, ctl(1,0,0,0,2'b00,2'b00,2'b00));
      fb_acc(32'h3000);
      chk("R5 either type takes fetch", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R6: direction
      cur_req = "R6";
      cfgw(4, ctl(1,0,0,0,2'b00,2'b01,2'b10));
      mb_acc(32'h3000, 32'h0, 1, 2'b10);
      chk("R6 write vs read-only", {30'd0, brk_req}, 32'd0);
      mb_acc(32'h3000, 32'h0, 0, 2'b10);
      chk("R6 read hit", {30'd0, brk_req}, 32'd1);
      clear_all();
      cfgw(4, ctl(1,0,0,0,2'b00,2'b10,2'b00));
      mb_acc(32'h3000, 32'h0, 0, 2'b10);
      chk("R6 read vs write-only", {30'd0, brk_req}, 32'd0);
      fb_acc(32'h3000);
      chk("R6 fetch counts as read", {30'd0, brk_req}, 32'd0);
      mb_acc(32'h3000, 32'h0, 1, 2'b10);
      chk("R6 write hit", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R7: size
      cur_req = "R7";
      cfgw(4, ctl(1,0,0,0,2'b10,2'b00,2'b10));
      mb_acc(32'h3000, 32'h0, 0, 2'b00);
      chk("R7 byte vs word", {30'd0, brk_req}, 32'd0);
      mb_acc(32'h3000, 32'h0, 0, 2'b01);
      chk("R7 word hit", {30'd0, brk_req}, 32'd1);
      clear_all();
      cfgw(4, ctl(1,0,0,0,2'b11,2'b00,2'b10));
      mb_acc(32'h3000, 32'h0, 0, 2'b10);
      chk("R7 long hit", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R9: post-execution fetch break
      cur_req = "R9";
      setch(0, 32'h4000, 32'h0, 32'h0, 32'hFFFF_FFFF, ctl(1,1,0,0,2'b00,2'b00,2'b01));
      fb_acc(32'h4000);
      chk("R9 no request at fetch", {30'd0, brk_req}, 32'd0);
      chk("R11 trigger on post fetch", {31'd0, trig_o}, 32'd1);
      retire(32'h4004);
      chk("R9 other retire ignored", {30'd0, brk_req}, 32'd0);
      retire(32'h4000);
      chk("R9 retire raises request", {30'd0, brk_req}, 32'd1);
      chk("R9 post flag", {30'd0, brk_post}, 32'd1);
      clear_all();
      chk("R10 post flag cleared", {30'd0, brk_post}, 32'd0);
      retire(32'h4000);
      chk("R9 pending consumed", {30'd0, brk_req}, 32'd0);

      // R10: sticky, set wins over clear
      cur_req = "R10";
      setch(0, 32'h5000, 32'h0, 32'h0, 32'hFFFF_FFFF, ctl(1,0,0,0,2'b00,2'b00,2'b10));
      mb_acc(32'h5000, 32'h0, 0, 2'b10);
      step(); step();
      chk("R10 sticky", {30'd0, brk_req}, 32'd1);
      mb_vld = 1; mb_addr = 32'h5000;
      cfgw(15, 32'h1);
      mb_vld = 0;
      chk("R10 set wins over clear", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R11: back-to-back hits
      cur_req = "R11";
      mb_acc(32'h5000, 32'h0, 0, 2'b10);
      chk("R11 first pulse", {31'd0, trig_o}, 32'd1);
      mb_acc(32'h5000, 32'h0, 0, 2'b10);
      chk("R11 second pulse", {31'd0, trig_o}, 32'd1);
      step();
      chk("R11 pulse ends", {31'd0, trig_o}, 32'd0);
      clear_all();

      // R12: independence
      cur_req = "R12";
      setch(1, 32'h5000, 32'h0, 32'h0, 32'hFFFF_FFFF, ctl(1,0,1,1,2'b00,2'b00,2'b00));
      db_acc(32'h5000, 32'h0);
      chk("R12 only channel 1", {30'd0, brk_req}, 32'd2);
      mb_acc(32'h5000, 32'h0, 0, 2'b10);
      chk("R12 both channels", {30'd0, brk_req}, 32'd3);
      cfgw(15, 32'h2);
      chk("R12 clear channel 1 only", {30'd0, brk_req}, 32'd1);
      clear_all();

      // R13: enable bit
      cur_req = "R13";
      cfgw(4, ctl(0,0,0,0,2'b00,2'b00,2'b10));
      mb_acc(32'h5000, 32'h0, 0, 2'b10);
      chk("R13 disabled no request", {30'd0, brk_req}, 32'd0);
      chk("R13 disabled no trigger", {31'd0, trig_o}, 32'd0);

      step();
      done = 1;
      summary();
      $finish;
   end

endmodule